// File: doc/BRIEF.md
# Shared-Bus Processor Datapath

This block is the datapath of a 32-bit processor in which every register talks through one common internal bus. It holds a bank of general registers and the program counter, instruction, scratch, ALU-operand, ALU-result, memory-address and memory-data registers. It also has a combinational ALU. In every clock cycle an external sequencer picks at most one source to place a value on the bus. Any number of destinations may capture that value at the next rising edge. A register-to-register move therefore takes exactly one cycle, and one value can be copied to several registers in the same cycle.

The ALU takes its first operand from a two-way selector, which offers either the operand register or the constant 4 (used to step the program counter). Its second operand is whatever is on the bus. Its result can be written only into the result register. The memory-data register connects the bus to the external memory data lines in both directions. The memory-address register drives the external address lines at all times. All control lines are plain inputs. Several simultaneous drivers are reported on a conflict output and are not prevented.

Top module: `sbus_datapath`

## Requirements
- R1: A register whose load enable is 1 holds the bus value of that cycle after the next rising clock edge. This covers the general registers, PC, IR, TEMP, Y, Z (ALU result), MAR and MDR (bus load).
- R2: A register whose load enable is 0 keeps its value across the clock edge, whatever is on the bus.
- R3: Several load enables may be asserted in one cycle, and every selected register captures the same bus value.
- R4: When exactly one output enable is 1, `bus` equals that register's value. When none is 1, `bus` is all zeros and `bus_conflict` is 0.
- R5: When two or more output enables are 1, `bus_conflict` is 1 and `bus` is the bitwise OR of the enabled registers.
- R6: The ALU first operand A is register Y when `alu_a_four`=0 and the constant 4 when `alu_a_four`=1. The second operand B is the current bus value.
- R7: `alu_op` encodings: 00 gives A+B+cin, 01 gives A+~B+cin (A−B when cin=1), 10 gives A^B, and 11 gives B. All results are taken modulo 2^32.
- R8: Z captures the ALU result on a clock edge where `z_ld`=1. Otherwise Z is unchanged, even while the ALU is working.
- R9: MDR loads from `mem_rdata` when `mdr_ld_mem`=1 and from the bus when only `mdr_ld_bus`=1. When both are 1, the memory input wins.
- R10: `mem_wdata` equals MDR while `mdr_wr_oe`=1 and is zero otherwise.
- R11: `mem_addr` always shows MAR. MAR is loaded only from the bus.
- R12: A synchronous active-high `rst` clears every register to zero at the clock edge.
- R13: A value moved from one register to another appears in the destination right after the single clock edge that ends the move cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gpr_ld | input | NREG | Load enables of the general registers |
| gpr_oe | input | NREG | Bus output enables of the general registers |
| pc_ld | input | 1 | PC load enable |
| pc_oe | input | 1 | PC bus output enable |
| ir_ld | input | 1 | IR load enable |
| ir_oe | input | 1 | IR bus output enable |
| tmp_ld | input | 1 | TEMP load enable |
| tmp_oe | input | 1 | TEMP bus output enable |
| y_ld | input | 1 | Y (ALU operand) load enable |
| y_oe | input | 1 | Y bus output enable |
| z_ld | input | 1 | Z captures the ALU result |
| z_oe | input | 1 | Z bus output enable |
| mar_ld | input | 1 | MAR load enable from the bus |
| mdr_ld_bus | input | 1 | MDR load from the bus |
| mdr_ld_mem | input | 1 | MDR load from memory (has priority) |
| mdr_oe | input | 1 | MDR bus output enable |
| mdr_wr_oe | input | 1 | MDR drives the memory write data |
| alu_a_four | input | 1 | ALU operand A select: 0 = Y, 1 = constant 4 |
| alu_op | input | 2 | ALU operation code |
| alu_cin | input | 1 | ALU carry-in |
| mem_rdata | input | W | External memory read data |
| mem_addr | output | W | External memory address (MAR) |
| mem_wdata | output | W | External memory write data |
| bus | output | W | Internal bus value |
| bus_conflict | output | 1 | More than one bus driver is enabled |

## Verification
The embedded assertions check several things on every cycle. Each loaded register must hold the previous bus value, and unloaded registers must stay stable. MDR must follow the memory input whenever its memory load is on. MAR must appear on the address port, and a lone Z driver must show up intact on the bus. Other behaviour can only be shown by the bench's scenarios. These include the ALU arithmetic for each operation code and carry-in, the constant-4 path used for stepping the PC, the OR value and flag under a driver clash, copying one value to two registers at once, and the clearing effect of a mid-run reset.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] gpr_ld,
  input  logic [NREG-1:0] gpr_oe,
  input  logic            pc_ld,
  input  logic            pc_oe,
  input  logic            ir_ld,
  input  logic            ir_oe,
  input  logic            tmp_ld,
  input  logic            tmp_oe,
  input  logic            y_ld,
  input  logic            y_oe,
  input  logic            z_ld,
  input  logic            z_oe,
  input  logic            mar_ld,
  input  logic            mdr_ld_bus,
  input  logic            mdr_ld_mem,
  input  logic            mdr_oe,
  input  logic            mdr_wr_oe,
  input  logic            alu_a_four,
  input  logic [1:0]      alu_op,
  input  logic            alu_cin,
  input  logic [W-1:0]    mem_rdata,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic [W-1:0]    bus,
  output logic            bus_conflict
);

  localparam int          NSRC = NREG + 6;
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0]    gpr [NREG];
  logic [W-1:0]    pc, ir, tmp, y, z, mar, mdr;
  logic [W-1:0]    src [NSRC];
  logic [NSRC-1:0] oe;
  logic [W-1:0]    alu_a, alu_y;

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)            gpr[g] <= '0;
      else if (gpr_ld[g]) gpr[g] <= bus;
    end
    assign src[g] = gpr[g];
    assign oe[g]  = gpr_oe[g];
  end

  assign src[NREG]   = pc;   assign oe[NREG]   = pc_oe;
  assign src[NREG+1] = ir;   assign oe[NREG+1] = ir_oe;
  assign src[NREG+2] = tmp;  assign oe[NREG+2] = tmp_oe;
  assign src[NREG+3] = y;    assign oe[NREG+3] = y_oe;
  assign src[NREG+4] = z;    assign oe[NREG+4] = z_oe;
  assign src[NREG+5] = mdr;  assign oe[NREG+5] = mdr_oe;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      if (oe[i]) bus = bus | src[i];
  end

  assign bus_conflict = ($countones(oe) > 1);

  assign alu_a = alu_a_four ? STEP : y;

  always_comb begin
    case (alu_op)
      2'b00:   alu_y = alu_a + bus + W'(alu_cin);
      2'b01:   alu_y = alu_a + ~bus + W'(alu_cin);
      2'b10:   alu_y = alu_a ^ bus;
      default: alu_y = bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      tmp <= '0;
      y   <= '0;
      z   <= '0;
      mar <= '0;
      mdr <= '0;
    end else begin
      if (pc_ld)           pc  <= bus;
      if (ir_ld)           ir  <= bus;
      if (tmp_ld)          tmp <= bus;
      if (y_ld)            y   <= bus;
      if (z_ld)            z   <= alu_y;
      if (mar_ld)          mar <= bus;
      if (mdr_ld_mem)      mdr <= mem_rdata;
      else if (mdr_ld_bus) mdr <= bus;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr_wr_oe ? mdr : '0;

  a_r1_pc_load: assert property (@(posedge clk) disable iff (rst)
    (!rst && pc_ld) |=> pc == $past(bus));
  a_r1_gpr0_load: assert property (@(posedge clk) disable iff (rst)
    (!rst && gpr_ld[0]) |=> gpr[0] == $past(bus));
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ir_ld) |=> $stable(ir));
  a_r8_z_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !z_ld) |=> $stable(z));
  a_r8_z_pass: assert property (@(posedge clk) disable iff (rst)
    (!rst && z_ld && alu_op == 2'b11) |=> z == $past(bus));
  a_r4_z_drive: assert property (@(posedge clk) disable iff (rst)
    (z_oe && !bus_conflict) |-> bus == z);
  a_r9_mem_first: assert property (@(posedge clk) disable iff (rst)
    (!rst && mdr_ld_mem) |=> mdr == $past(mem_rdata));
  a_r11_addr: assert property (@(posedge clk) disable iff (rst)
    (!rst && mar_ld) |=> mem_addr == $past(bus));
  a_r5_clash: assert property (@(posedge clk) disable iff (rst)
    (pc_oe && mdr_oe) |-> bus_conflict);

endmodule

// File: tb/sbus_datapath_bench.sv
module sbus_datapath_bench;
  localparam int W = 32;
  localparam int NREG = 8;
  localparam int NV = 9;

  // {op[99:98], a_four[97], cin[96], y[95:64], b[63:32], expected[31:0]}
  localparam logic [99:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {2'b00, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0020, 32'h0000_0031},
    {2'b01, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_0001, 32'h0000_00FF},
    {2'b01, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0001, 32'h0000_00FE},
    {2'b10, 1'b0, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0},
    {2'b11, 1'b0, 1'b0, 32'h1234_5678, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {2'b00, 1'b1, 1'b0, 32'h0000_0999, 32'h0000_1000, 32'h0000_1004},
    {2'b01, 1'b1, 1'b1, 32'h0000_0999, 32'h0000_0001, 32'h0000_0003}
  };

  logic clk = 0, rst = 1;
  logic [NREG-1:0] gpr_ld, gpr_oe;
  logic pc_ld, pc_oe, ir_ld, ir_oe, tmp_ld, tmp_oe, y_ld, y_oe, z_ld, z_oe;
  logic mar_ld, mdr_ld_bus, mdr_ld_mem, mdr_oe, mdr_wr_oe, alu_a_four, alu_cin;
  logic [1:0] alu_op;
  logic [W-1:0] mem_rdata, mem_addr, mem_wdata, bus;
  logic bus_conflict;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sbus_datapath #(.W(W), .NREG(NREG)) u_sbus_datapath (
    .clk(clk), .rst(rst), .gpr_ld(gpr_ld), .gpr_oe(gpr_oe),
    .pc_ld(pc_ld), .pc_oe(pc_oe), .ir_ld(ir_ld), .ir_oe(ir_oe),
    .tmp_ld(tmp_ld), .tmp_oe(tmp_oe), .y_ld(y_ld), .y_oe(y_oe),
    .z_ld(z_ld), .z_oe(z_oe), .mar_ld(mar_ld), .mdr_ld_bus(mdr_ld_bus),
    .mdr_ld_mem(mdr_ld_mem), .mdr_oe(mdr_oe), .mdr_wr_oe(mdr_wr_oe),
    .alu_a_four(alu_a_four), .alu_op(alu_op), .alu_cin(alu_cin),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .bus(bus), .bus_conflict(bus_conflict));

  task automatic clr();
    gpr_ld = '0; gpr_oe = '0;
    {pc_ld, pc_oe, ir_ld, ir_oe, tmp_ld, tmp_oe, y_ld, y_oe, z_ld, z_oe} = '0;
    {mar_ld, mdr_ld_bus, mdr_ld_mem, mdr_oe, mdr_wr_oe, alu_a_four, alu_cin} = '0;
    alu_op = 2'b00;
    mem_rdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_to_mdr(input logic [W-1:0] v);
    clr(); mem_rdata = v; mdr_ld_mem = 1; tick();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    rst = 1; tick(); tick(); rst = 0;

    // R12 / R4: reset state, no driver
    #1 chk("R4 idle bus", bus, '0);
    chk("R4 idle conflict", {31'b0, bus_conflict}, 0);
    chk("R12 mem_addr", mem_addr, '0);
    for (int i = 0; i < NREG; i++) begin
      clr(); gpr_oe[i] = 1; #1 chk("R12 gpr reset", bus, '0);
    end
    clr(); pc_oe = 1; #1 chk("R12 pc reset", bus, '0);
    clr(); z_oe = 1; #1 chk("R12 z reset", bus, '0);

    // R6 R7 R8: vector table through Y, bus and Z
    for (int v = 0; v < NV; v++) begin
      mem_to_mdr(VEC[v][95:64]);
      clr(); mdr_oe = 1; y_ld = 1; tick();
      mem_to_mdr(VEC[v][63:32]);
      clr(); mdr_oe = 1; z_ld = 1;
      alu_op = VEC[v][99:98]; alu_a_four = VEC[v][97]; alu_cin = VEC[v][96];
      tick();
      clr(); z_oe = 1; #1 chk("R7 alu vector", bus, VEC[v][31:0]);
    end

    // R8: Z unchanged when not loaded
    mem_to_mdr(32'h0000_7777);
    clr(); mdr_oe = 1; alu_op = 2'b11; tick();
    clr(); z_oe = 1; #1 chk("R8 z hold", bus, 32'h0000_0003);

    // R1 R3 R13: load R3, then copy R3 into R4 and R7 in one cycle
    mem_to_mdr(32'h0000_A5A5);
    clr(); mdr_oe = 1; gpr_ld[3] = 1; tick();
    clr(); gpr_oe[3] = 1; gpr_ld[4] = 1; gpr_ld[7] = 1; tick();
    clr(); gpr_oe[4] = 1; #1 chk("R13 R4 after one edge", bus, 32'h0000_A5A5);
    clr(); gpr_oe[7] = 1; #1 chk("R3 R7 copy", bus, 32'h0000_A5A5);
    clr(); gpr_oe[3] = 1; #1 chk("R1 R3 source kept", bus, 32'h0000_A5A5);
    clr(); gpr_oe[5] = 1; #1 chk("R2 R5 untouched", bus, '0);

    // R5: two drivers
    mem_to_mdr(32'h0000_0F0F);
    clr(); gpr_oe[3] = 1; mdr_oe = 1; #1 chk("R5 OR value", bus, 32'h0000_AFAF);
    chk("R5 conflict flag", {31'b0, bus_conflict}, 1);
    clr(); mdr_oe = 1; #1 chk("R4 single driver", bus, 32'h0000_0F0F);
    chk("R4 no conflict", {31'b0, bus_conflict}, 0);

    // R9: memory input beats bus, then bus-only load
    clr(); gpr_oe[3] = 1; mdr_ld_bus = 1; mdr_ld_mem = 1; mem_rdata = 32'h11; tick();
    clr(); mdr_oe = 1; #1 chk("R9 mem priority", bus, 32'h11);
    clr(); gpr_oe[3] = 1; mdr_ld_bus = 1; tick();
    clr(); mdr_oe = 1; #1 chk("R9 bus load", bus, 32'h0000_A5A5);

    // R10: memory write data gate
    clr(); mdr_wr_oe = 1; #1 chk("R10 wdata on", mem_wdata, 32'h0000_A5A5);
    clr(); #1 chk("R10 wdata off", mem_wdata, '0);

    // R11 R2: MAR load and hold
    clr(); gpr_oe[3] = 1; mar_ld = 1; tick();
    chk("R11 mar load", mem_addr, 32'h0000_A5A5);
    clr(); mdr_oe = 1; mdr_ld_mem = 1; mem_rdata = 32'h5; tick();
    chk("R2 mar hold", mem_addr, 32'h0000_A5A5);

    // R6: PC step through constant 4
    clr(); gpr_oe[3] = 1; pc_ld = 1; tick();
    clr(); pc_oe = 1; alu_a_four = 1; alu_op = 2'b00; z_ld = 1; tick();
    clr(); z_oe = 1; pc_ld = 1; tick();
    clr(); pc_oe = 1; #1 chk("R6 pc step", bus, 32'h0000_A5A9);

    // R12: mid-run reset
    clr(); rst = 1; tick(); rst = 0;
    clr(); pc_oe = 1; #1 chk("R12 pc cleared", bus, '0);
    clr(); gpr_oe[3] = 1; #1 chk("R12 R3 cleared", bus, '0);
    chk("R12 mar cleared", mem_addr, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule